// File: doc/BRIEF.md
# Memory-Mapped Address Decoder with Serial, Tick and Display Peripherals

This block is the memory-side front end of a 16-bit processor. The CPU presents a byte address, write data, read and write strobes and a byte/word size flag. The block sorts each access into one of three regions: a read-only program area at the bottom of the map, an I/O window in the second quarter, and a read/write data area in the upper half. Accesses to the two array regions become select strobes toward external ROM and RAM arrays, and the read data from the selected array is steered back to the CPU. Accesses inside the I/O window reach a small set of registers that live in the block itself.

The I/O registers are a single-character receive holder fed by an 8-bit serial input, a one-cycle transmit strobe bus, a counter of external tick pulses, and a bank of seven-segment digit registers. Reading the receive holder or the tick counter consumes its contents: the register returns to zero when the read completes. Reads return data in the same cycle as the strobe, and every register update takes effect at the next rising clock edge.

Top module: `addr_io_decoder`

## Requirements
- R1: An access with addr below 0x4000 is a ROM access: during a read, rom_sel is 1 and rdata equals rom_rdata. An access with addr[15]=1 is a RAM access: ram_sel is 1 on a read or write, rdata equals ram_rdata on a read, and ram_we is 1 on a write. Addresses 0x4000 to 0x7FFF assert neither select.
- R2: In any cycle where ser_in is non-zero, its value is stored in the receive holder at the next clock edge; a zero ser_in leaves the holder unchanged.
- R3: ser_in_busy is 1 exactly when the receive holder contains a non-zero value.
- R4: A byte read (byte_sel=1) at 0x4100 returns {8'h00, holder} on rdata in the same cycle and leaves the holder zero afterwards, unless ser_in is non-zero in that cycle, in which case the new character is stored instead.
- R5: A non-zero ser_in that arrives while the holder is already non-zero replaces the stored character.
- R6: A byte write at 0x4102 places wdata[7:0] on ser_out for exactly the one cycle after the write; ser_out is zero in every other cycle.
- R7: The tick counter increases by one at each clock edge where tick is 1.
- R8: A word read (byte_sel=0) at 0x4000 returns the tick count on rdata in the same cycle; afterwards the counter is 0, or 1 if tick was 1 in the read cycle.
- R9: A byte write at 0x4200+i (i from 0 to 7) sets digit i, carried on digits[8i+7:8i], to wdata[7:0] at the next edge; the other digits keep their values.
- R10: Reads of I/O addresses other than the two above, or of those two with the other access size, return zero and consume nothing; writes to unused I/O addresses, word writes to the I/O registers, and writes below 0x4000 change no output and assert neither ram_we nor ram_sel.
- R11: After reset the receive holder, tick counter, ser_out and all digits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | CPU byte address |
| wdata | input | 16 | CPU write data; byte writes use bits 7:0 |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| byte_sel | input | 1 | 1 for byte access, 0 for word access |
| rdata | output | 16 | Read data back to the CPU, zero when no read |
| rom_sel | output | 1 | Read select toward the ROM array |
| ram_sel | output | 1 | Access select toward the RAM array |
| ram_we | output | 1 | Write enable toward the RAM array |
| rom_rdata | input | 16 | Data from the ROM array |
| ram_rdata | input | 16 | Data from the RAM array |
| ser_in | input | 8 | Incoming serial character, zero when idle |
| tick | input | 1 | Tick pulse, counted once per high cycle |
| ser_out | output | 8 | Outgoing serial character, zero when idle |
| ser_in_busy | output | 1 | A received character is waiting |
| digits | output | 8*DIGITS | Digit registers, digit i at bits 8i+7:8i |

## Verification
The bench uses the defaults, DIGITS=8 and TICK_W=16, so every digit address from 0x4200 to 0x4207 and the first unused address after them are within reach, while counter wrap-around is not, since it would need 65536 ticks. With these values the bench drives collisions between an incoming character and a consuming read, a tick coinciding with a counter read, back-to-back characters into a full holder, and accesses of the wrong size to the live I/O addresses.

// File: rtl/addr_io_decoder.sv
module addr_io_decoder #(
  parameter int DIGITS = 8,
  parameter int TICK_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [15:0]           addr,
  input  logic [15:0]           wdata,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic                  byte_sel,
  output logic [15:0]           rdata,
  output logic                  rom_sel,
  output logic                  ram_sel,
  output logic                  ram_we,
  input  logic [15:0]           rom_rdata,
  input  logic [15:0]           ram_rdata,
  input  logic [7:0]            ser_in,
  input  logic                  tick,
  output logic [7:0]            ser_out,
  output logic                  ser_in_busy,
  output logic [8*DIGITS-1:0]   digits
);

  localparam logic [15:0] RX_ADDR   = 16'h4100;
  localparam logic [15:0] TX_ADDR   = 16'h4102;
  localparam logic [15:0] TICK_ADDR = 16'h4000;
  localparam logic [7:0]  DIG_PAGE  = 8'h42;

  logic in_rom, in_io, in_ram;
  logic rx_rd, tick_rd, tx_wr, io_byte_wr;
  logic [7:0] rx_buf;
  logic [TICK_W-1:0] tick_cnt;
  logic [15:0] io_rdata;

  assign in_rom = (addr[15:14] == 2'b00);
  assign in_io  = (addr[15:14] == 2'b01);
  assign in_ram = addr[15];

  assign rom_sel = rd_en & in_rom;
  assign ram_sel = in_ram & (rd_en | wr_en);
  assign ram_we  = in_ram & wr_en;

  assign rx_rd      = rd_en & byte_sel & (addr == RX_ADDR);
  assign tick_rd    = rd_en & ~byte_sel & (addr == TICK_ADDR);
  assign io_byte_wr = wr_en & byte_sel & in_io;
  assign tx_wr      = io_byte_wr & (addr == TX_ADDR);

  always_comb begin
    io_rdata = '0;
    if (rx_rd)   io_rdata = {8'h00, rx_buf};
    if (tick_rd) io_rdata = 16'(tick_cnt);
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (in_rom)      rdata = rom_rdata;
      else if (in_ram) rdata = ram_rdata;
      else             rdata = io_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                rx_buf <= '0;
    else if (ser_in != 0)   rx_buf <= ser_in;
    else if (rx_rd)         rx_buf <= '0;
  end
  assign ser_in_busy = (rx_buf != 0);

  always_ff @(posedge clk) begin
    if (rst)          tick_cnt <= '0;
    else if (tick_rd) tick_cnt <= TICK_W'(tick);
    else if (tick)    tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        ser_out <= '0;
    else if (tx_wr) ser_out <= wdata[7:0];
    else            ser_out <= '0;
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic hit;
    assign hit = io_byte_wr & (addr[15:8] == DIG_PAGE) & (addr[7:0] == 8'(i));
    always_ff @(posedge clk) begin
      if (rst)      digits[8*i +: 8] <= '0;
      else if (hit) digits[8*i +: 8] <= wdata[7:0];
    end
  end

  // R1
  rom_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_rom) |-> (!ram_we && !ram_sel));

  // R2
  rx_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_in != 0) |=> (ser_in_busy && rx_buf == $past(ser_in)));

  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && ser_in == 0) |=> !ser_in_busy);

  // R6
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_wr |=> (ser_out == 0));

  // R8
  tick_read_chk: assert property (@(posedge clk) disable iff (rst)
    tick_rd |=> (tick_cnt == TICK_W'($past(tick))));

  // R9
  dig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_byte_wr && addr[15:8] == DIG_PAGE) |=> $stable(digits));

endmodule

// File: tb/tb_addr_io_decoder.sv
module tb_addr_io_decoder;
  localparam int DIGITS = 8;

  logic clk = 0, rst = 1;
  logic [15:0] addr = 0, wdata = 0, rdata;
  logic rd_en = 0, wr_en = 0, byte_sel = 0;
  logic rom_sel, ram_sel, ram_we;
  logic [15:0] rom_rdata = 16'hBEEF, ram_rdata = 16'hCAFE;
  logic [7:0] ser_in = 0, ser_out;
  logic tick = 0, ser_in_busy;
  logic [8*DIGITS-1:0] digits;

  addr_io_decoder #(.DIGITS(DIGITS), .TICK_W(16)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd_en(rd_en), .wr_en(wr_en),
    .byte_sel(byte_sel), .rdata(rdata), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .ram_we(ram_we), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .ser_in(ser_in),
    .tick(tick), .ser_out(ser_out), .ser_in_busy(ser_in_busy), .digits(digits));

  always #4 clk = ~clk;

  typedef enum int {S_RDATA, S_BUSY, S_TX, S_DIG, S_ROMSEL, S_RAMSEL, S_RAMWE} sig_t;
  typedef struct {int due; sig_t sig; logic [63:0] exp; string req;} item_t;
  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  function automatic logic [63:0] obs(sig_t s);
    case (s)
      S_RDATA:  return 64'(rdata);
      S_BUSY:   return 64'(ser_in_busy);
      S_TX:     return 64'(ser_out);
      S_DIG:    return 64'(digits);
      S_ROMSEL: return 64'(rom_sel);
      S_RAMSEL: return 64'(ram_sel);
      default:  return 64'(ram_we);
    endcase
  endfunction

  always begin
    @(negedge clk);
    #3;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [63:0] a;
        a = obs(q[i].sig);
        checks++;
        if (a !== q[i].exp) begin
          fails++;
          $display("FAIL %s sig=%s actual=%h expected=%h", q[i].req, q[i].sig.name(), a, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic drive(bit r, bit w, bit b, logic [15:0] a, logic [15:0] d,
                       logic [7:0] s, bit t);
    @(negedge clk);
    rd_en = r; wr_en = w; byte_sel = b; addr = a; wdata = d; ser_in = s; tick = t;
  endtask

  task automatic idle();
    drive(0, 0, 0, 16'h0000, 16'h0000, 8'h00, 0);
  endtask

  task automatic exp_at(int off, sig_t s, logic [63:0] v, string req);
    item_t it;
    it.due = cyc + off; it.sig = s; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(); idle();
    // R11: state under reset
    exp_at(0, S_BUSY, 0, "R11"); exp_at(0, S_TX, 0, "R11"); exp_at(0, S_DIG, 0, "R11");
    idle(); rst = 0;
    // R11: counter reads zero after reset
    drive(1, 0, 0, 16'h4000, 0, 0, 0); exp_at(0, S_RDATA, 0, "R11");

    // R1: region decode and read steering
    drive(1, 0, 0, 16'h1234, 0, 0, 0);
    exp_at(0, S_RDATA, 16'hBEEF, "R1"); exp_at(0, S_ROMSEL, 1, "R1"); exp_at(0, S_RAMSEL, 0, "R1");
    drive(1, 0, 0, 16'h3FFF, 0, 0, 0); exp_at(0, S_ROMSEL, 1, "R1");
    drive(1, 0, 0, 16'h8010, 0, 0, 0);
    exp_at(0, S_RDATA, 16'hCAFE, "R1"); exp_at(0, S_RAMSEL, 1, "R1"); exp_at(0, S_ROMSEL, 0, "R1");
    drive(0, 1, 0, 16'h9000, 16'h1111, 0, 0);
    exp_at(0, S_RAMWE, 1, "R1"); exp_at(0, S_RAMSEL, 1, "R1");
    drive(1, 0, 0, 16'h7FFE, 0, 0, 0);
    exp_at(0, S_ROMSEL, 0, "R1"); exp_at(0, S_RAMSEL, 0, "R1");

    // R2 R3: capture then busy
    drive(0, 0, 0, 0, 0, 8'h41, 0); exp_at(1, S_BUSY, 1, "R2_R3");
    idle(); exp_at(1, S_BUSY, 1, "R2");
    // R4: consuming read
    drive(1, 0, 1, 16'h4100, 0, 0, 0);
    exp_at(0, S_RDATA, 16'h0041, "R4"); exp_at(1, S_BUSY, 0, "R4_R3");
    idle();

    // R5: overwrite when full
    drive(0, 0, 0, 0, 0, 8'h41, 0);
    drive(0, 0, 0, 0, 0, 8'h42, 0);
    drive(1, 0, 1, 16'h4100, 0, 8'h43, 0);
    exp_at(0, S_RDATA, 16'h0042, "R5"); exp_at(1, S_BUSY, 1, "R4");
    drive(1, 0, 1, 16'h4100, 0, 0, 0);
    exp_at(0, S_RDATA, 16'h0043, "R4"); exp_at(1, S_BUSY, 0, "R4");

    // R6: one-cycle transmit strobe
    drive(0, 1, 1, 16'h4102, 16'h995A, 0, 0);
    exp_at(0, S_TX, 0, "R6"); exp_at(1, S_TX, 8'h5A, "R6"); exp_at(2, S_TX, 0, "R6");
    idle(); idle();

    // R7 R8: count and consume
    drive(0, 0, 0, 0, 0, 0, 1); drive(0, 0, 0, 0, 0, 0, 1); drive(0, 0, 0, 0, 0, 0, 1);
    idle();
    drive(1, 0, 0, 16'h4000, 0, 0, 0); exp_at(0, S_RDATA, 3, "R7_R8");
    drive(1, 0, 0, 16'h4000, 0, 0, 0); exp_at(0, S_RDATA, 0, "R8");
    drive(0, 0, 0, 0, 0, 0, 1); drive(0, 0, 0, 0, 0, 0, 1);
    drive(1, 0, 0, 16'h4000, 0, 0, 1); exp_at(0, S_RDATA, 2, "R8");
    drive(1, 0, 0, 16'h4000, 0, 0, 0); exp_at(0, S_RDATA, 1, "R8");
    drive(1, 0, 0, 16'h4000, 0, 0, 0); exp_at(0, S_RDATA, 0, "R8");

    // R9: digit writes
    drive(0, 1, 1, 16'h4203, 16'h007E, 0, 0); exp_at(1, S_DIG, 64'h00000000_7E000000, "R9");
    drive(0, 1, 1, 16'h4200, 16'hAB11, 0, 0); exp_at(1, S_DIG, 64'h00000000_7E000011, "R9");
    drive(0, 1, 1, 16'h4207, 16'h00FF, 0, 0); exp_at(1, S_DIG, 64'hFF000000_7E000011, "R9");
    drive(0, 1, 1, 16'h4203, 16'h0000, 0, 0); exp_at(1, S_DIG, 64'hFF000000_00000011, "R9");
    idle();

    // R10: ignored writes and empty reads
    drive(0, 1, 1, 16'h4208, 16'h00AA, 0, 0);
    exp_at(1, S_DIG, 64'hFF000000_00000011, "R10"); exp_at(1, S_TX, 0, "R10");
    drive(0, 1, 0, 16'h4201, 16'h00AA, 0, 0); exp_at(1, S_DIG, 64'hFF000000_00000011, "R10");
    drive(0, 1, 0, 16'h4102, 16'h0055, 0, 0); exp_at(1, S_TX, 0, "R10");
    drive(0, 1, 1, 16'h0100, 16'h0033, 0, 0);
    exp_at(0, S_RAMWE, 0, "R10"); exp_at(0, S_RAMSEL, 0, "R10"); exp_at(0, S_ROMSEL, 0, "R10");
    exp_at(1, S_DIG, 64'hFF000000_00000011, "R10");
    drive(1, 0, 1, 16'h4300, 0, 0, 0); exp_at(0, S_RDATA, 0, "R10");
    drive(0, 0, 0, 0, 0, 8'h77, 0);
    drive(1, 0, 0, 16'h4100, 0, 0, 0); exp_at(0, S_RDATA, 0, "R10"); exp_at(1, S_BUSY, 1, "R10");
    drive(1, 0, 1, 16'h4100, 0, 0, 0); exp_at(0, S_RDATA, 16'h0077, "R10");
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(1, 0, 1, 16'h4000, 0, 0, 0); exp_at(0, S_RDATA, 0, "R10");
    drive(1, 0, 0, 16'h4000, 0, 0, 0); exp_at(0, S_RDATA, 1, "R10");

    idle(); idle(); idle();
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard actual=%0d pending expected=0", q.size());
    end
    finish_run();
  end
endmodule